// File: doc/BRIEF.md
# Three-Stage Pipelined Integer Core

This block is a small 32-bit integer processor core built as three pipeline stages: fetch, execute, and memory/write-back. It drives a synchronous instruction memory port and a synchronous data memory port. It runs a compact instruction subset: register-register arithmetic and logic, add-immediate, word load and store, two conditional branches and an absolute jump.

The core has no stall logic. Hazards are handled in three ways. The instruction after a branch or jump always executes. The instruction after a load sees the register's old contents. A single path forwards the execute result of the instruction one ahead into the ALU operands. An instruction two or more places behind its producer reads the new value from the register file, because the file is written on the clock edge that ends the memory stage. Software or a compiler must schedule around the two delay slots.

Top module: `tsc_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the program counter returns to the reset address (0 by default) and no store is presented. The next fetch after reset is from that address.
- R2: `imem_addr` carries the program counter. Memory returns the word one cycle later, and that word executes in the following cycle. With no redirect, the address advances by 4 on every clock edge and the core never stalls.
- R3: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0], 16-bit immediate [15:0] and 26-bit jump index [25:0]. Opcode 0x00 with function 0x20/0x22/0x24/0x25/0x26/0x2A performs add/sub/and/or/xor/signed-less-than into rd. Opcode 0x08 adds the sign-extended immediate to rs and writes the sum to rt. The all-zero word and unlisted codes change nothing.
- R4: If the instruction just ahead wrote a register with an ALU result, that result replaces the register-file value for any operand that reads the same register. This applies to ALU inputs, store data and branch comparisons.
- R5: An instruction two or more places behind a producer reads the new value, including after a load.
- R6: The instruction immediately after a load (opcode 0x23) sees the destination register's previous value.
- R7: Opcodes 0x04 (equal) and 0x05 (not equal) compare rs with rt. The following instruction always executes. When the branch is taken, the next fetch is the delay-slot address plus the sign-extended immediate times 4.
- R8: Opcode 0x02 always executes its delay slot and then fetches from {delay-slot address[31:28], index, 2'b00}.
- R9: Register 0 always reads as zero. Writes to it are dropped, and it is never forwarded.
- R10: A store (opcode 0x2B) drives `dmem_we`, address rs+sign-extended immediate, and rt data during its execute cycle. A load presents its address during execute and writes `dmem_rdata` into rt on the edge that ends its memory stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Fetch byte address (program counter) |
| imem_rdata | input | 32 | Instruction word, one cycle after address |
| dmem_addr | output | 32 | Data byte address, captured at the next edge |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | 32 | Load data, one cycle after address |

## Verification
An instruction fetched at edge k executes between edges k+1 and k+2. Its store, or its redirect of the fetch address, is therefore visible in the half cycle before edge k+2. The bench records `imem_addr` at each falling edge. A taken branch fetched at edge k is therefore expected to show its delay-slot address at sample k+1 and its target at sample k+2. Register results are not observable directly, so the program stores each one. The stored words are compared only after the program has settled into its closing loop, and each stored value is computed by hand from the requirement it tests.

// File: rtl/tsc_pkg.sv
`timescale 1ns/1ps
// Shared encodings and decoded-control type for the three-stage core.
// Assumes 32-bit words and 32 architectural registers.
package tsc_pkg;
    localparam int XW = 32;
    localparam int RW = 5;

    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] OPC_JMP  = 6'h02;
    localparam logic [5:0] OPC_BEQ  = 6'h04;
    localparam logic [5:0] OPC_BNE  = 6'h05;
    localparam logic [5:0] OPC_ADDI = 6'h08;
    localparam logic [5:0] OPC_LW   = 6'h23;
    localparam logic [5:0] OPC_SW   = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_XOR = 6'h26;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT
    } alu_op_e;

    typedef struct packed {
        logic [RW-1:0] rs;
        logic [RW-1:0] rt;
        logic [RW-1:0] wr_reg;
        logic          wr_en;
        logic          use_imm;
        logic          is_load;
        logic          is_store;
        logic          is_beq;
        logic          is_bne;
        logic          is_jump;
        alu_op_e       alu_op;
        logic [XW-1:0] imm;
        logic [25:0]   jidx;
    } ctrl_t;
endpackage

// File: rtl/tsc_decode.sv
`timescale 1ns/1ps
// Instruction decoder: turns one instruction word into control fields.
// Assumes an invalid slot (after reset) decodes to a no-op reading r0.
module tsc_decode
    import tsc_pkg::*;
(
    input  logic [XW-1:0] instr,
    input  logic          valid,
    output ctrl_t         ctrl
);
    logic [5:0] opc;
    logic [5:0] fn;
    assign opc = instr[31:26];
    assign fn  = instr[5:0];

    // Field extraction and opcode/function classification.
    always_comb begin
        ctrl        = '0;
        ctrl.imm    = {{(XW-16){instr[15]}}, instr[15:0]};
        ctrl.jidx   = instr[25:0];
        ctrl.alu_op = ALU_ADD;
        if (valid) begin
            ctrl.rs = instr[25:21];
            ctrl.rt = instr[20:16];
            case (opc)
                OPC_REG: begin
                    ctrl.wr_reg = instr[15:11];
                    ctrl.wr_en  = 1'b1;
                    case (fn)
                        FN_ADD:  ctrl.alu_op = ALU_ADD;
                        FN_SUB:  ctrl.alu_op = ALU_SUB;
                        FN_AND:  ctrl.alu_op = ALU_AND;
                        FN_OR:   ctrl.alu_op = ALU_OR;
                        FN_XOR:  ctrl.alu_op = ALU_XOR;
                        FN_SLT:  ctrl.alu_op = ALU_SLT;
                        default: ctrl.wr_en  = 1'b0;
                    endcase
                end
                OPC_ADDI: begin
                    ctrl.wr_reg  = instr[20:16];
                    ctrl.wr_en   = 1'b1;
                    ctrl.use_imm = 1'b1;
                end
                OPC_LW: begin
                    ctrl.wr_reg  = instr[20:16];
                    ctrl.wr_en   = 1'b1;
                    ctrl.use_imm = 1'b1;
                    ctrl.is_load = 1'b1;
                end
                OPC_SW: begin
                    ctrl.use_imm  = 1'b1;
                    ctrl.is_store = 1'b1;
                end
                OPC_BEQ: ctrl.is_beq  = 1'b1;
                OPC_BNE: ctrl.is_bne  = 1'b1;
                OPC_JMP: ctrl.is_jump = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tsc_alu.sv
`timescale 1ns/1ps
// Integer ALU for the execute stage. Purely combinational.
module tsc_alu
    import tsc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);
    // Operation select.
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            ALU_SLT: y = {{(W-1){1'b0}}, $signed(a) < $signed(b)};
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/tsc_regfile.sv
`timescale 1ns/1ps
// Register file with two combinational read ports and one write port.
// Entry 0 is a constant zero. A write lands on the rising edge, so a read
// in the following cycle sees it (write before read across stages).
module tsc_regfile #(
    parameter int W  = 32,
    parameter int N  = 32,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] regs [N];

    assign regs[0] = '0;

    for (genvar gi = 1; gi < N; gi++) begin : g_reg
        logic [W-1:0] q;
        // Load this entry when it is the write target.
        always_ff @(posedge clk) begin
            if (we && waddr == AW'(gi)) begin
                q <= wdata;
            end
        end
        assign regs[gi] = q;
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/tsc_core.sv
`timescale 1ns/1ps
// Three-stage core: fetch (PC addresses instruction memory, whose output
// register acts as the instruction register), execute (ALU, branch compare,
// data memory address), memory/write-back (load data and ALU result written
// to the register file at the closing edge). Never stalls; one branch delay
// slot, one load delay slot, one forwarding path from memory stage to execute.
// Assumes both memories return read data one cycle after the address.
module tsc_core
    import tsc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata
);
    localparam int NREG = 1 << RW;

    logic [XW-1:0] pc_q;
    logic          x_valid_q;
    logic          m_wen_q;
    logic          m_load_q;
    logic [RW-1:0] m_rd_q;
    logic [XW-1:0] m_alu_q;

    ctrl_t         xc;
    logic [XW-1:0] rf_a, rf_b, op_a, op_b, alu_b, alu_y, wb_data;
    logic [XW-1:0] br_target, jmp_target, pc_next;
    logic          fwd_a, fwd_b, equal, taken, redirect;

    tsc_decode u_dec (
        .instr (imem_rdata),
        .valid (x_valid_q),
        .ctrl  (xc)
    );

    tsc_regfile #(.W(XW), .N(NREG)) u_rf (
        .clk     (clk),
        .we      (m_wen_q),
        .waddr   (m_rd_q),
        .wdata   (wb_data),
        .raddr_a (xc.rs),
        .raddr_b (xc.rt),
        .rdata_a (rf_a),
        .rdata_b (rf_b)
    );

    // Forwarding from the ALU result held in the memory stage.
    assign fwd_a = m_wen_q && !m_load_q && (m_rd_q != '0) && (m_rd_q == xc.rs);
    assign fwd_b = m_wen_q && !m_load_q && (m_rd_q != '0) && (m_rd_q == xc.rt);
    assign op_a  = fwd_a ? m_alu_q : rf_a;
    assign op_b  = fwd_b ? m_alu_q : rf_b;
    assign alu_b = xc.use_imm ? xc.imm : op_b;

    tsc_alu #(.W(XW)) u_alu (
        .a  (op_a),
        .b  (alu_b),
        .op (xc.alu_op),
        .y  (alu_y)
    );

    // Branch resolution; pc_q already holds the delay-slot address.
    assign equal      = (op_a == op_b);
    assign taken      = (xc.is_beq && equal) || (xc.is_bne && !equal);
    assign redirect   = taken || xc.is_jump;
    assign br_target  = pc_q + (xc.imm << 2);
    assign jmp_target = {pc_q[31:28], xc.jidx, 2'b00};
    assign pc_next    = !redirect ? pc_q + 32'd4 : (xc.is_jump ? jmp_target : br_target);

    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = op_b;
    assign dmem_we    = xc.is_store;
    assign wb_data    = m_load_q ? dmem_rdata : m_alu_q;

    // Pipeline advance; reset returns the PC and empties both stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q      <= RESET_PC;
            x_valid_q <= 1'b0;
            m_wen_q   <= 1'b0;
            m_load_q  <= 1'b0;
            m_rd_q    <= '0;
            m_alu_q   <= '0;
        end else begin
            pc_q      <= pc_next;
            x_valid_q <= 1'b1;
            m_wen_q   <= xc.wr_en;
            m_load_q  <= xc.is_load;
            m_rd_q    <= xc.wr_reg;
            m_alu_q   <= alu_y;
        end
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (imem_addr == RESET_PC && !dmem_we));

    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect |=> imem_addr == $past(imem_addr) + 32'd4);

    p_alu_forward_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && xc.rs != '0 && $past(xc.wr_en && !xc.is_load)
         && xc.rs == $past(xc.wr_reg)) |-> op_a == $past(alu_y));

    p_load_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && xc.rs != '0 && $past(xc.is_load)
         && xc.rs == $past(xc.wr_reg)) |-> op_a == rf_a);

    p_branch_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !xc.is_jump) |=> imem_addr == $past(imem_addr) + ($past(xc.imm) << 2));

    p_jump_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xc.is_jump |=> imem_addr[27:0] == {$past(xc.jidx), 2'b00});

    p_zero_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xc.rs == '0 |-> op_a == '0);
endmodule

// File: tb/tsc_core_test.sv
`timescale 1ns/1ps
// Self-checking bench: runs a fixed program, traces the fetch address and
// compares the stored words against a table of hand-computed results.
module tsc_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    logic [31:0] trace [100];
    int checks = 0;
    int fails  = 0;
    int wp     = 0;
    bit done   = 1'b0;

    localparam int NEXP = 13;
    localparam logic [31:0] EXP_VAL [NEXP] = '{
        32'd7, 32'd12, 32'd33, 32'd12, 32'd0, 32'd1, 32'd7,
        32'hFFFF_FFFF, 32'd1, 32'd2, 32'd7, 32'd5, 32'd10
    };

    always #2.5 clk = ~clk;

    tsc_core uut (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
    );

    // Behavioural synchronous memories (read-old on write).
    always @(posedge clk) begin
        imem_rdata <= imem[imem_addr[7:2]];
        dmem_rdata <= dmem[dmem_addr[7:2]];
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    function automatic string tag_of(input int i);
        case (i)
            0, 12:          return "R4";
            1:              return "R5";
            2:              return "R6";
            3:              return "R10";
            4:              return "R9";
            5, 6:           return "R7";
            7:              return "R8";
            default:        return "R3";
        endcase
    endfunction

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rt, input int rs, input int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction
    function automatic logic [31:0] enc_j(input int idx);
        return {6'h02, idx[25:0]};
    endfunction

    task automatic put(input logic [31:0] w);
        imem[wp] = w;
        wp++;
    endtask

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load_program();
        for (int i = 0; i < 64; i++) begin imem[i] = '0; dmem[i] = 32'hDEAD_BEEF; end
        put(enc_i(6'h08, 5, 0, 33));       // 0   r5 = 33
        put(enc_i(6'h08, 1, 0, 5));        // 4   r1 = 5
        put(enc_i(6'h08, 2, 0, 7));        // 8   r2 = 7
        put(enc_r(6'h20, 3, 1, 2));        // 12  r3 = 12, r2 forwarded
        put(enc_r(6'h22, 4, 3, 1));        // 16  r4 = 7, r3 forwarded
        put(enc_i(6'h2B, 4, 0, 0));        // 20  m0 = r4 (forwarded store data)
        put(enc_i(6'h2B, 3, 0, 4));        // 24  m1 = r3 (read from file)
        put(enc_i(6'h23, 5, 0, 4));        // 28  r5 = m1
        put(enc_r(6'h20, 6, 5, 0));        // 32  load slot: old r5
        put(enc_r(6'h20, 7, 5, 0));        // 36  new r5
        put(enc_i(6'h2B, 6, 0, 8));        // 40  m2 = r6
        put(enc_i(6'h2B, 7, 0, 12));       // 44  m3 = r7
        put(enc_i(6'h08, 0, 0, 99));       // 48  write to r0 dropped
        put(enc_r(6'h20, 8, 0, 0));        // 52  r8 = r0 + r0
        put(enc_i(6'h2B, 8, 0, 16));       // 56  m4 = r8
        put(enc_i(6'h04, 1, 1, 2));        // 60  beq taken -> 72
        put(enc_i(6'h08, 9, 0, 1));        // 64  delay slot
        put(enc_i(6'h08, 9, 0, 2));        // 68  skipped
        put(enc_i(6'h2B, 9, 0, 20));       // 72  m5 = r9
        put(enc_i(6'h05, 1, 1, 5));        // 76  bne not taken
        put(enc_i(6'h08, 10, 0, 3));       // 80  delay slot
        put(enc_i(6'h08, 10, 10, 4));      // 84  r10 = 7
        put(enc_i(6'h2B, 10, 0, 24));      // 88  m6 = r10
        put(enc_j(26));                    // 92  jump -> 104
        put(enc_i(6'h08, 11, 0, -1));      // 96  delay slot
        put(enc_i(6'h08, 11, 0, 0));       // 100 skipped
        put(enc_i(6'h2B, 11, 0, 28));      // 104 m7 = r11
        put(enc_r(6'h2A, 12, 11, 1));      // 108 signed -1 < 5
        put(enc_r(6'h26, 13, 1, 2));       // 112 xor
        put(enc_r(6'h25, 14, 1, 2));       // 116 or
        put(enc_r(6'h24, 15, 1, 2));       // 120 and
        put(enc_i(6'h2B, 12, 0, 32));      // 124
        put(enc_i(6'h2B, 13, 0, 36));      // 128
        put(enc_i(6'h2B, 14, 0, 40));      // 132
        put(enc_i(6'h2B, 15, 0, 44));      // 136
        put(enc_i(6'h08, 16, 0, 5));       // 140 r16 = 5
        put(enc_i(6'h04, 1, 16, 2));       // 144 beq uses forwarded r16 -> 156
        put(enc_i(6'h08, 17, 0, 10));      // 148 delay slot
        put(enc_i(6'h08, 17, 0, 20));      // 152 skipped
        put(enc_i(6'h2B, 17, 0, 48));      // 156 m12 = r17
        put(enc_i(6'h04, 0, 0, -1));       // 160 closing loop
    endtask

    initial begin
        load_program();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "fetch address in reset", imem_addr, 32'h0);
        check("R1", "store strobe in reset", {31'd0, dmem_we}, 32'h0);
        rst_n = 1'b1;
        for (int k = 0; k < 100; k++) begin
            trace[k] = imem_addr;
            @(negedge clk);
        end
        check("R1", "first fetch after reset", trace[0], 32'd0);
        check("R2", "fetch step 1", trace[1], 32'd4);
        check("R2", "fetch step 2", trace[2], 32'd8);
        check("R7", "delay slot fetched", trace[16], 32'd64);
        check("R7", "branch target fetched", trace[17], 32'd72);
        check("R8", "jump target fetched", trace[24], 32'd104);
        for (int i = 0; i < NEXP; i++) begin
            check(tag_of(i), $sformatf("stored word %0d", i), dmem[i], EXP_VAL[i]);
        end
        check("R7", "skipped path stored nothing", dmem[13], 32'hDEAD_BEEF);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "fetch address after mid-run reset", imem_addr, 32'h0);
        check("R1", "no store after mid-run reset", {31'd0, dmem_we}, 32'h0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule